// File: doc/BRIEF.md
# Radix-4 SRT Floating-Point Divider

A sequential divider for 64-bit binary floating-point numbers. A one-cycle start pulse captures a dividend and a divisor. The block then forms the quotient significand two bits per cycle with a radix-4 SRT digit recurrence, normalizes it, and presents the packed result together with a one-cycle done pulse. The quotient sign is the XOR of the operand signs and is handled apart from the magnitude. The exponent is formed by subtracting the biased exponents.

On each iteration the shifted partial remainder is classified into one of five ranges, bounded by plus and minus one half and three halves of the divisor. A small table maps the range to a quotient digit in {-2,-1,0,1,2}. Positive digits are shifted into one register and the magnitudes of negative digits into another. When the recurrence ends, the second register is subtracted from the first. If the final remainder is negative, one unit is then subtracted, which gives the exact truncated quotient. A divisor with a zero exponent field counts as zero: the result is infinity and a divide-by-zero flag is raised. Subnormal, infinite and NaN operands and exponent overflow are outside the supported range. Rounding is by truncation only.

Top module: `srt4_fp_divider`

## Requirements
- R1: After reset, busy, done, div_zero and quotient are all zero.
- R2: A start pulse sampled while busy is low captures both operands, and busy is high from the next cycle. Counting the edge that samples start as the first, done rises at the 30th rising edge and stays high for exactly one cycle. busy is low while done is high, and done stays low at every earlier edge.
- R3: A start pulse sampled while busy is high is ignored. It does not change the result or the timing of the division already running.
- R4: The result sign (bit 63) is the XOR of the operand sign bits, and this includes the zero and infinity results.
- R5: For normal operands, the 52-bit result fraction (bits 51:0) is the truncated quotient. With significands ma and mb (hidden bit included), it is floor(ma*2^52/mb) when ma >= mb, and floor(ma*2^53/mb) otherwise, with the leading one dropped.
- R6: For normal operands, the result exponent field (bits 62:52) is Ea - Eb + 1023. It is one less when ma < mb, because the quotient is then shifted left by one.
- R7: Each iteration selects exactly one digit in {-2..2}. The positive and negative digit registers never both hold a nonzero digit in the same position. The partial remainder stays within [-d/2, d/2), where d is the scaled divisor.
- R8: A divisor whose exponent field is zero sets div_zero and returns exponent 2047 with fraction 0 (infinity), whatever the dividend is.
- R9: A zero dividend (exponent field 0) with a nonzero divisor returns a zero magnitude with div_zero low.
- R10: quotient and div_zero hold their values from one done pulse until the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a division |
| dividend | input | 64 | Dividend in 64-bit binary floating-point format |
| divisor | input | 64 | Divisor in 64-bit binary floating-point format |
| busy | output | 1 | High while a division is in progress |
| done | output | 1 | One-cycle pulse when the result is valid |
| quotient | output | 64 | Packed result |
| div_zero | output | 1 | Set with done when the divisor is zero |

## Verification
The remainder-bound and digit-exclusivity assertions assume normal operands, where the hidden bit makes the scaled divisor lie between 2^54 and 2^55. A zero exponent field is used only for the two special cases, and there the forced hidden bit keeps the recurrence bounded as well. The assertions on the result fields assume that the exponent difference never leaves the 1..2046 range. To stay within that, the stimulus draws both biased exponents from a narrow band around the bias. Significand fractions are swept over edge patterns (all zeros, all ones, a single top bit) and scrambled values, in every pairing, so that both normalization branches and negative final remainders occur.

// File: rtl/srt4_fp_divider.sv
module srt4_fp_divider (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [63:0] dividend,
  input  logic [63:0] divisor,
  output logic        busy,
  output logic        done,
  output logic [63:0] quotient,
  output logic        div_zero
);
  localparam int ITER = 28;
  localparam int QW   = 2 * ITER;
  localparam int RW   = QW + 2;
  localparam int CW   = $clog2(ITER + 1);

  logic signed [RW-1:0] rem, dvs, t, h, h3, nxt;
  logic [QW-1:0] qpos, qneg, qraw, qfix;
  logic [CW-1:0] cnt;
  logic [1:0]    pd, nd, kind;
  logic [2:0]    rng;
  logic          sgn, lead;
  logic [12:0]   exq, eres;
  logic [51:0]   frac;

  assign t  = rem <<< 2;
  assign h  = dvs >>> 1;
  assign h3 = dvs + h;
  assign rng = 3'(t >= -h3) + 3'(t >= -h) + 3'(t >= h) + 3'(t >= h3);

  always_comb begin
    pd = 2'd0; nd = 2'd0; nxt = t;
    case (rng)
      3'd0:    begin nd = 2'd2; nxt = t + (dvs <<< 1); end
      3'd1:    begin nd = 2'd1; nxt = t + dvs;         end
      3'd2:    begin                                    end
      3'd3:    begin pd = 2'd1; nxt = t - dvs;         end
      default: begin pd = 2'd2; nxt = t - (dvs <<< 1); end
    endcase
  end

  assign qraw = qpos - qneg;
  assign qfix = qraw - QW'(rem[RW-1]);
  assign lead = qfix[QW-2];
  assign frac = lead ? qfix[QW-3:QW-54] : qfix[QW-4:QW-55];
  assign eres = exq - 13'(!lead);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; quotient <= '0; div_zero <= 1'b0;
      rem <= '0; dvs <= '0; qpos <= '0; qneg <= '0; cnt <= '0;
      sgn <= 1'b0; exq <= '0; kind <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy <= 1'b1;
        cnt  <= '0;
        qpos <= '0;
        qneg <= '0;
        rem  <= RW'({1'b1, dividend[51:0]});
        dvs  <= RW'({1'b1, divisor[51:0], 2'b00});
        sgn  <= dividend[63] ^ divisor[63];
        exq  <= 13'(dividend[62:52]) - 13'(divisor[62:52]) + 13'd1023;
        kind <= (divisor[62:52] == 11'd0) ? 2'd2 :
                (dividend[62:52] == 11'd0) ? 2'd1 : 2'd0;
      end else if (busy) begin
        if (cnt == CW'(ITER)) begin
          busy     <= 1'b0;
          done     <= 1'b1;
          div_zero <= (kind == 2'd2);
          case (kind)
            2'd2:    quotient <= {sgn, 11'h7ff, 52'd0};
            2'd1:    quotient <= {sgn, 63'd0};
            default: quotient <= {sgn, eres[10:0], frac};
          endcase
        end else begin
          rem  <= nxt;
          qpos <= {qpos[QW-3:0], pd};
          qneg <= {qneg[QW-3:0], nd};
          cnt  <= cnt + 1'b1;
        end
      end
    end
  end

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy && !done); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy)); // R2
  AST_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rem >= -h) && (rem < h)); // R7
  AST_DIGIT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !((qpos[1:0] != 2'd0) && (qneg[1:0] != 2'd0))); // R7
  AST_DZ_INF: assert property (@(posedge clk) disable iff (!rst_n)
    done && div_zero |-> quotient[62:0] == {11'h7ff, 52'd0}); // R8
  AST_NORM_EXP: assert property (@(posedge clk) disable iff (!rst_n)
    done && !div_zero && quotient[62:52] != 11'd0 |-> quotient[62:52] != 11'h7ff); // R6
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(quotient) && $stable(div_zero)); // R10
endmodule

// File: tb/tb_srt4_fp_divider.sv
module tb_srt4_fp_divider;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [63:0] dividend = '0, divisor = '0;
  logic busy, done, div_zero;
  logic [63:0] quotient;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  srt4_fp_divider dut (.clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
    .divisor(divisor), .busy(busy), .done(done), .quotient(quotient), .div_zero(div_zero));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [51:0] frac_pat(input int i);
    logic [63:0] v;
    if (i == 0) return 52'd0;
    if (i == 1) return {52{1'b1}};
    if (i == 2) return {1'b1, 51'd0};
    if (i == 3) return 52'd1;
    v = 64'(i) * 64'h9E3779B97F4A7C15;
    v = v ^ (v >> 29);
    return v[51:0];
  endfunction

  function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b);
    logic [52:0] ma, mb;
    logic [106:0] num, qq;
    int e;
    ma = {1'b1, a[51:0]};
    mb = {1'b1, b[51:0]};
    num = (ma >= mb) ? (107'(ma) << 52) : (107'(ma) << 53);
    qq  = num / 107'(mb);
    e = int'(a[62:52]) - int'(b[62:52]) + 1023 - ((ma < mb) ? 1 : 0);
    return {a[63] ^ b[63], 11'(e), qq[51:0]};
  endfunction

  task automatic run(input logic [63:0] a, input logic [63:0] b, input bit intr,
                     output logic [63:0] res, output logic dz);
    bit early;
    @(negedge clk);
    dividend = a; divisor = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0; dividend = ~a; divisor = ~b;
    chk(busy === 1'b1, "R2 busy after start", 64'(busy), 64'd1);
    early = 1'b0;
    for (int k = 1; k <= 28; k++) begin
      if (intr && k == 5) begin
        start = 1'b1; dividend = 64'h3ff0_0000_0000_0000; divisor = 64'h4000_0000_0000_0000;
      end
      if (intr && k == 6) start = 1'b0;
      @(negedge clk);
      if (done !== 1'b0) early = 1'b1;
    end
    start = 1'b0;
    chk(!early, "R2 no early done", 64'(early), 64'd0);
    @(negedge clk);
    chk(done === 1'b1 && busy === 1'b0, "R2 done at 30th edge", {62'd0, done, busy}, 64'd2);
    res = quotient; dz = div_zero;
    @(negedge clk);
    chk(done === 1'b0, "R2 done one cycle", 64'(done), 64'd0);
    chk(quotient === res && div_zero === dz, "R10 result held", quotient, res);
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] r, a, b, e;
    logic dz;
    repeat (3) @(negedge clk);
    chk(busy === 0 && done === 0 && div_zero === 0 && quotient === 64'd0,
        "R1 reset state", quotient, 64'd0);
    rst_n = 1'b1;

    for (int i = 0; i < 14; i++) begin
      for (int j = 0; j < 14; j++) begin
        a = {1'(i % 2), 11'(1000 + (i * 7) % 47), frac_pat(i)};
        b = {1'(j % 3 == 1), 11'(1000 + (j * 11) % 47), frac_pat(j)};
        e = model(a, b);
        run(a, b, 1'b0, r, dz);
        chk(r[63] === e[63], "R4 sign", r, e);
        chk(r[51:0] === e[51:0], "R5 R7 fraction", r, e);
        chk(r[62:52] === e[62:52], "R6 exponent", r, e);
        chk(dz === 1'b0, "R8 no div_zero", 64'(dz), 64'd0);
      end
    end

    a = 64'h4008_0000_0000_0000; b = 64'hc000_0000_0000_0000;
    e = model(a, b);
    run(a, b, 1'b1, r, dz);
    chk(r === e, "R3 start while busy ignored", r, e);

    for (int s = 0; s < 4; s++) begin
      a = {1'(s & 1), 11'(s == 3 ? 0 : 1030), frac_pat(s + 5)};
      b = {1'(s >> 1), 11'd0, frac_pat(s + 9)};
      run(a, b, 1'b0, r, dz);
      e = {1'((s & 1) ^ (s >> 1)), 11'h7ff, 52'd0};
      chk(dz === 1'b1, "R8 div_zero flag", 64'(dz), 64'd1);
      chk(r === e, "R8 R4 infinity", r, e);
    end

    for (int s = 0; s < 4; s++) begin
      a = {1'(s & 1), 11'd0, frac_pat(s + 2)};
      b = {1'(s >> 1), 11'(1010 + s), frac_pat(s + 7)};
      run(a, b, 1'b0, r, dz);
      e = {1'((s & 1) ^ (s >> 1)), 63'd0};
      chk(dz === 1'b0, "R9 no flag", 64'(dz), 64'd0);
      chk(r === e, "R9 R4 signed zero", r, e);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule